// File: doc/BRIEF.md
# Copy-Control Packet CRC-6 Generator

This block assembles a copy-generation control packet from raw register contents and, when asked, overwrites the six check positions at the top of the packet with a CRC-6 computed over the lower bits. It handles two packet formats: a short 20-bit word, whose CRC covers 14 payload bits, and a long 134-bit packet, whose CRC covers 128 bits. Each format has its own CRC enable. When the enable for the selected format is clear, the register bits pass through unchanged, including the six top bits.

A one-cycle `start` pulse captures the packet type, the raw bits and the relevant enable. The block then feeds the covered bits one per clock, lowest index first, into a serial CRC register preset to all ones. It ends by presenting the finished packet on `pkt_out` together with a one-cycle `done` pulse. The packet stays on the output until the next completion.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. The transition `start` moves it to `ST_SHIFT`.
- `ST_SHIFT` consumes one covered bit per clock. The transition `last bit` moves it to `ST_PATCH`.
- `ST_PATCH` registers the assembled packet and raises `done`. It always returns to `ST_IDLE` on the next edge.

The output uses the same path and the same latency whether the CRC is enabled or not.

Top module: `cgms_crc_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pkt_out` is all zeros and `done` and `busy` are 0 until the first completion.
- R2: The CRC uses the generator x^6 + x + 1 and a 6-bit register `r` preset to 111111. Covered bits enter in ascending index order. For each bit `d`, `fb = d ^ r[5]` and `r` becomes `{r[4:0],0}` XOR `{0,0,0,0,fb,fb}`. Check position `COV+k` receives `r[5-k]` for k = 0..5.
- R3: For a short packet (`pkt_long`=0) with CRC on, bits 0..13 of `pkt_out` equal `raw_bits[13:0]`, bits 14..19 hold the CRC, and bits 20..133 are zero.
- R4: For a long packet (`pkt_long`=1) with CRC on, bits 0..127 of `pkt_out` equal `raw_bits[127:0]` and bits 128..133 hold the CRC computed over those 128 bits.
- R5: With the CRC off, a short packet outputs `raw_bits[19:0]` unchanged in bits 0..19 with zeros above, and a long packet outputs all 134 raw bits unchanged.
- R6: `crc_en_short` controls only short packets and `crc_en_long` controls only long packets.
- R7: `busy` is 1 from the edge that samples `start` until the edge that raises `done`. `done` is a one-cycle pulse that is first high after the (COV+1)-th clock edge following the start edge, where COV is 14 (short) or 128 (long).
- R8: A `start` pulse while `busy` is 1 is ignored. It does not change the captured data, the result or the timing, and it does not begin a further calculation.
- R9: `pkt_out` changes only on the edge that raises `done`. Changes on the inputs after the start edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to build a packet |
| pkt_long | input | 1 | Packet type: 0 = 20-bit word, 1 = 134-bit packet |
| crc_en_short | input | 1 | CRC insertion enable for the 20-bit word |
| crc_en_long | input | 1 | CRC insertion enable for the 134-bit packet |
| raw_bits | input | 134 | Register contents; the short word uses bits 19:0 |
| pkt_out | output | 134 | Assembled packet, held until the next completion |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 20-bit word with 14 covered bits and a 134-bit packet with 128 covered bits. With these values both formats are reachable, each with its own enable and its own latency of 15 or 129 edges. The bench sets payloads of all zeros, all ones and mixed patterns. It sets the bits above the short word so that the masking shows at the output. It fires a second start in the middle of a 128-bit run, so the capture hold and the ignore path are tested on the longer count.

// File: rtl/cgms_crc_pkg.sv
package cgms_crc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PATCH = 2'd2
    } cc_state_t;

    localparam int          CC_CRC_W  = 6;
    localparam logic [5:0]  CC_POLY   = 6'b000011;  // x^6 + x + 1, top term implied
    localparam logic [5:0]  CC_PRESET = 6'b111111;

endpackage

// File: rtl/cgms_crc_core.sv
module cgms_crc_core #(
    parameter int                W      = 6,
    parameter logic [W-1:0]      POLY   = 6'b000011,
    parameter logic [W-1:0]      PRESET = 6'b111111
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nxt;
    logic         fb;

    assign fb = din ^ crc_q[W-1];

    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign crc_nxt[0] = POLY[0] & fb;
            end else begin : g_upper
                assign crc_nxt[i] = crc_q[i-1] ^ (POLY[i] & fb);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= PRESET;
        end else if (init) begin
            crc_q <= PRESET;
        end else if (step) begin
            crc_q <= crc_nxt;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/cgms_bit_pick.sv
module cgms_bit_pick #(
    parameter int N  = 134,
    parameter int IW = 8
) (
    input  logic [N-1:0]  data,
    input  logic [IW-1:0] idx,
    output logic          bit_o
);

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) begin
                bit_o = data[i];
            end
        end
    end

endmodule

// File: rtl/cgms_pkt_build.sv
module cgms_pkt_build #(
    parameter int SLEN = 20,
    parameter int SCOV = 14,
    parameter int LLEN = 134,
    parameter int LCOV = 128,
    parameter int W    = 6
) (
    input  logic [LLEN-1:0] raw,
    input  logic [W-1:0]    crc,
    input  logic            is_long,
    input  logic            crc_on,
    output logic [LLEN-1:0] pkt
);

    always_comb begin
        pkt = '0;
        if (is_long) begin
            pkt = raw;
            if (crc_on) begin
                for (int k = 0; k < W; k++) begin
                    pkt[LCOV+k] = crc[W-1-k];
                end
            end
        end else begin
            pkt[SLEN-1:0] = raw[SLEN-1:0];
            if (crc_on) begin
                for (int k = 0; k < W; k++) begin
                    pkt[SCOV+k] = crc[W-1-k];
                end
            end
        end
    end

endmodule

// File: rtl/cgms_crc_gen.sv
module cgms_crc_gen
    import cgms_crc_pkg::*;
#(
    parameter int SHORT_LEN = 20,
    parameter int LONG_LEN  = 134
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                pkt_long,
    input  logic                crc_en_short,
    input  logic                crc_en_long,
    input  logic [LONG_LEN-1:0] raw_bits,
    output logic [LONG_LEN-1:0] pkt_out,
    output logic                busy,
    output logic                done
);

    localparam int SHORT_COV = SHORT_LEN - CC_CRC_W;
    localparam int LONG_COV  = LONG_LEN - CC_CRC_W;
    localparam int CW        = $clog2(LONG_LEN);

    cc_state_t             state_q, state_d;
    logic [CW-1:0]         cnt_q;
    logic [LONG_LEN-1:0]   raw_q;
    logic                  long_q;
    logic                  en_q;
    logic                  accept;
    logic                  last_bit;
    logic                  cur_bit;
    logic [CC_CRC_W-1:0]   crc_val;
    logic [LONG_LEN-1:0]   built;

    assign accept   = (state_q == ST_IDLE) && start;
    assign last_bit = long_q ? (cnt_q == CW'(LONG_COV - 1))
                             : (cnt_q == CW'(SHORT_COV - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_SHIFT;
            ST_SHIFT: if (last_bit) state_d = ST_PATCH;
            ST_PATCH:               state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // capture and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            long_q <= 1'b0;
            en_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            raw_q  <= raw_bits;
            long_q <= pkt_long;
            en_q   <= pkt_long ? crc_en_long : crc_en_short;
            cnt_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    cgms_bit_pick #(
        .N  (LONG_LEN),
        .IW (CW)
    ) u_pick (
        .data  (raw_q),
        .idx   (cnt_q),
        .bit_o (cur_bit)
    );

    cgms_crc_core #(
        .W      (CC_CRC_W),
        .POLY   (CC_POLY),
        .PRESET (CC_PRESET)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (accept),
        .step  (state_q == ST_SHIFT),
        .din   (cur_bit),
        .crc   (crc_val)
    );

    cgms_pkt_build #(
        .SLEN (SHORT_LEN),
        .SCOV (SHORT_COV),
        .LLEN (LONG_LEN),
        .LCOV (LONG_COV),
        .W    (CC_CRC_W)
    ) u_build (
        .raw     (raw_q),
        .crc     (crc_val),
        .is_long (long_q),
        .crc_on  (en_q),
        .pkt     (built)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= (state_q == ST_PATCH);
            if (state_q == ST_PATCH) begin
                pkt_out <= built;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/cgms_crc_gen_chk.sv
module cgms_crc_gen_chk #(
    parameter int SLEN = 20,
    parameter int LLEN = 134
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            busy,
    input  logic            done,
    input  logic [LLEN-1:0] pkt_out,
    input  logic            long_q,
    input  logic [LLEN-1:0] raw_q
);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy has dropped by the time done is seen
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: a completion is always preceded by a busy cycle
    p_done_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: output only moves on a completion edge
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pkt_out));

    // R8: captured data untouched while a calculation runs, even under start
    p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(raw_q));

    // R8: a start during busy does not extend or restart the run immediately
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(raw_q));

    // R3: short packets leave everything above the word at zero
    p_short_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !long_q) |-> (pkt_out[LLEN-1:SLEN] == '0));

endmodule

bind cgms_crc_gen cgms_crc_gen_chk #(
    .SLEN (SHORT_LEN),
    .LLEN (LONG_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .pkt_out (pkt_out),
    .long_q  (long_q),
    .raw_q   (raw_q)
);

// File: tb/cgms_crc_gen_tb.sv
module cgms_crc_gen_tb;

    localparam int SL = 20;
    localparam int LL = 134;
    localparam int SC = 14;
    localparam int LC = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          pkt_long;
    logic          crc_en_short;
    logic          crc_en_long;
    logic [LL-1:0] raw_bits;
    logic [LL-1:0] pkt_out;
    logic          busy;
    logic          done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cgms_crc_gen #(.SHORT_LEN(SL), .LONG_LEN(LL)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pkt_long     (pkt_long),
        .crc_en_short (crc_en_short),
        .crc_en_long  (crc_en_long),
        .raw_bits     (raw_bits),
        .pkt_out      (pkt_out),
        .busy         (busy),
        .done         (done)
    );

    function automatic logic [5:0] ref_crc(input logic [LL-1:0] d, input int n);
        logic [5:0] r;
        logic       fb;
        r = 6'h3F;
        for (int i = 0; i < n; i++) begin
            fb = d[i] ^ r[5];
            r  = {r[4:0], 1'b0};
            if (fb) r = r ^ 6'b000011;
        end
        return r;
    endfunction

    function automatic logic [LL-1:0] ref_pkt(input logic lng, input logic en,
                                              input logic [LL-1:0] d);
        logic [LL-1:0] p;
        logic [5:0]    r;
        int            cov;
        p = '0;
        if (lng) p = d;
        else     p[SL-1:0] = d[SL-1:0];
        cov = lng ? LC : SC;
        if (en) begin
            r = ref_crc(d, cov);
            for (int k = 0; k < 6; k++) p[cov+k] = r[5-k];
        end
        return p;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [LL-1:0] act, input logic [LL-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives one request and checks result and timing; optional mid-run start
    task automatic run_pkt(input string req, input logic lng, input logic en_s,
                           input logic en_l, input logic [LL-1:0] d,
                           input logic inject);
        logic [LL-1:0] exp;
        int            cyc;
        int            lat;
        exp = ref_pkt(lng, lng ? en_l : en_s, d);
        lat = (lng ? LC : SC) + 1;
        @(negedge clk);
        pkt_long     = lng;
        crc_en_short = en_s;
        crc_en_long  = en_l;
        raw_bits     = d;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {req, " R7 busy after start"}, LL'(busy), LL'(1));
        // R9: inputs moved after capture must not matter
        raw_bits     = ~d;
        crc_en_short = ~en_s;
        crc_en_long  = ~en_l;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                start    = 1'b1;
                pkt_long = ~lng;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(cyc == lat, {req, " R7 latency"}, LL'(cyc), LL'(lat));
        chk(pkt_out == exp, {req, " packet"}, pkt_out, exp);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {req, " R7/R8 single done, idle"},
            LL'({done, busy}), LL'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; pkt_long = 1'b0;
        crc_en_short = 1'b0; crc_en_long = 1'b0; raw_bits = '0;
        repeat (3) @(negedge clk);
        chk(pkt_out == '0 && done == 1'b0 && busy == 1'b0, "R1 during reset",
            {pkt_out[LL-3:0], done, busy}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pkt_out == '0 && done == 1'b0 && busy == 1'b0, "R1 after release",
            {pkt_out[LL-3:0], done, busy}, '0);
    endtask

    task automatic t_short_crc();
        run_pkt("R2 R3 short zero", 1'b0, 1'b1, 1'b0, '0, 1'b0);
        run_pkt("R2 R3 short ones", 1'b0, 1'b1, 1'b0, {LL{1'b1}}, 1'b0);
        run_pkt("R2 R3 short mixed", 1'b0, 1'b1, 1'b0,
                {{(LL-SL){1'b1}}, 20'hA5C3D}, 1'b0);
    endtask

    task automatic t_long_crc();
        run_pkt("R2 R4 long zero", 1'b1, 1'b0, 1'b1, '0, 1'b0);
        run_pkt("R2 R4 long mixed", 1'b1, 1'b0, 1'b1,
                {6'h15, 64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687}, 1'b0);
        run_pkt("R2 R4 long ones", 1'b1, 1'b0, 1'b1, {LL{1'b1}}, 1'b0);
    endtask

    task automatic t_bypass();
        run_pkt("R5 short bypass", 1'b0, 1'b0, 1'b0, {{(LL-SL){1'b1}}, 20'hFC001}, 1'b0);
        run_pkt("R5 long bypass", 1'b1, 1'b0, 1'b0,
                {6'h2A, 64'hDEAD_BEEF_0000_FFFF, 64'h1357_9BDF_2468_ACE0}, 1'b0);
    endtask

    task automatic t_enables();
        run_pkt("R6 long ignores short enable", 1'b1, 1'b1, 1'b0,
                {6'h3F, 128'h5555_AAAA_0F0F_F0F0_1234_5678_9ABC_DEF0}, 1'b0);
        run_pkt("R6 short ignores long enable", 1'b0, 1'b0, 1'b1,
                {{(LL-SL){1'b0}}, 20'hFFFFF}, 1'b0);
    endtask

    task automatic t_ignore_start();
        run_pkt("R8 start while busy", 1'b1, 1'b0, 1'b1,
                {6'h00, 64'hCAFE_F00D_1111_2222, 64'h3333_4444_5555_6666}, 1'b1);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 no extra run",
            LL'({busy, done}), LL'(0));
    endtask

    task automatic t_hold();
        logic [LL-1:0] held;
        held = pkt_out;
        @(negedge clk);
        raw_bits = {LL{1'b1}}; pkt_long = 1'b0;
        crc_en_short = 1'b1; crc_en_long = 1'b1;
        repeat (6) @(negedge clk);
        chk(pkt_out == held, "R9 output held while idle", pkt_out, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_short_crc();
        t_long_crc();
        t_bypass();
        t_enables();
        t_ignore_start();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule